// File: doc/BRIEF.md
# Three-Quarter Rate Fuse Word Encoder

This block encodes fuse payload data into the layout that is burned into a fuse array. A command first states the payload length and the mode. In coded mode, each six-byte group taken from the input stream becomes eight bytes. These are the six data bytes unchanged, one byte that is the XOR of the six, and one weighted-popcount byte. The eight bytes leave as two 32-bit little-endian words. A full 24-byte block therefore becomes 32 coded bytes, which is eight words. In repeat mode the block takes a 16-byte payload as four 32-bit beats and sends it out twice, giving eight words.

Commands with a length that cannot be encoded are refused. The block answers a refused command with a one-cycle error pulse and returns no data. Both streams use valid/ready handshakes, and the output holds its word for as long as the consumer stalls.

Top module: `fuse34_encoder`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `err` are 0 and `cmd_ready` is 1.
- R2: A command is refused in two cases. In coded mode, it is refused when `cmd_len` is 0, is not a multiple of 6, or is larger than MAX_BYTES (default 24). In repeat mode, it is refused when `cmd_len` differs from REP_BYTES (16). A refused command gives `err` = 1 for exactly the one cycle after its handshake and produces no output words. `cmd_ready` stays 1 afterwards.
- R3: In coded mode, `in_data` carries byte k of a group in bits [8k+7:8k]. The first output word of the group equals `in_data[31:0]`, which places bytes 0..3 with byte 0 in bits [7:0].
- R4: The second output word of a group carries bytes 4 and 5 in bits [15:0]. Its bits [23:16] hold the XOR of all six data bytes.
- R5: Bits [31:24] of the second word hold the sum over k = 0..5 of (k+1) times the number of set bits in byte k, taken modulo 256.
- R6: A coded command of length L yields exactly L/3 words, two per group in order. `out_last` is 1 on the final word only. After that final word the block accepts a new command.
- R7: In repeat mode, four input beats supply words from `in_data[31:0]`, and `in_data[47:32]` is ignored. The block then emits those four words in arrival order, twice, with `out_last` on the eighth word.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values on the next cycle.
- R9: The first word of a coded group is valid in the cycle after the group handshake.
- R10: While no command is active, `in_ready` is 0 and no output word is produced, whatever `in_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, can take a command |
| cmd_repeat | input | 1 | 1 selects repeat mode, 0 selects coded mode |
| cmd_len | input | LEN_W | Payload length in bytes |
| err | output | 1 | One-cycle pulse after a refused command |
| in_valid | input | 1 | Input group or word offered |
| in_ready | output | 1 | Block takes the input this cycle |
| in_data | input | 48 | Six data bytes (coded) or one word in [31:0] (repeat) |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Encoded output word |
| out_last | output | 1 | Final word of the payload |

## Verification
Refusal is visible one cycle after the command handshake. The bench samples `err` on the falling edge that follows that handshake, and again one cycle later to see it drop. A coded group's first word is due one cycle after the group is accepted, and the bench checks `out_valid` on the next falling edge. Words are captured only on falling edges where valid and ready are both high, so stalls never count twice. Changes to `out_ready` are applied just after a rising edge, so each one applies to a whole cycle.

// File: rtl/fuse34_encoder.sv
module fuse34_encoder #(
  parameter int MAX_BYTES = 24,
  parameter int REP_BYTES = 16,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_repeat,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [47:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_last
);
  localparam int GRP        = 6;
  localparam int MAX_GROUPS = MAX_BYTES / GRP;
  localparam int CNT_W      = $clog2(MAX_GROUPS + 1);
  localparam int REP_WORDS  = REP_BYTES / 4;
  localparam int REP_TOTAL  = 2 * REP_WORDS;
  localparam int RIDX_W     = $clog2(REP_TOTAL);
  localparam int RW_W       = $clog2(REP_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_CODE, S_RCOL, S_REMIT} state_t;

  state_t            state;
  logic [CNT_W-1:0]  left;
  logic              full, phase, err_q;
  logic [31:0]       w0, w1;
  logic [31:0]       rep [REP_WORDS];
  logic [RIDX_W-1:0] ridx;

  function automatic logic [7:0] wsum(input logic [47:0] d);
    logic [7:0] acc;
    acc = 8'd0;
    for (int i = 0; i < GRP; i++)
      acc = acc + 8'(i + 1) * 8'($countones(d[8*i +: 8]));
    return acc;
  endfunction

  wire [7:0] chk_x = in_data[7:0] ^ in_data[15:8] ^ in_data[23:16] ^
                     in_data[31:24] ^ in_data[39:32] ^ in_data[47:40];
  wire [7:0] chk_m = wsum(in_data);

  wire cmd_bad = cmd_repeat ? (cmd_len != LEN_W'(REP_BYTES))
                            : (cmd_len == '0 || (cmd_len % LEN_W'(GRP)) != '0 ||
                               cmd_len > LEN_W'(MAX_BYTES));
  wire [CNT_W-1:0] groups = CNT_W'(cmd_len / LEN_W'(GRP));

  assign cmd_ready = (state == S_IDLE);
  assign in_ready  = (state == S_CODE && !full) || state == S_RCOL;
  assign out_valid = (state == S_CODE && full) || state == S_REMIT;
  assign out_data  = (state == S_REMIT) ? rep[ridx[RW_W-1:0]] : (phase ? w1 : w0);
  assign out_last  = (state == S_REMIT) ? (ridx == RIDX_W'(REP_TOTAL - 1))
                                        : (full && phase && left == CNT_W'(1));
  assign err       = err_q;

  wire cmd_fire = cmd_valid && cmd_ready;
  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      left  <= '0;
      full  <= 1'b0;
      phase <= 1'b0;
      err_q <= 1'b0;
      ridx  <= '0;
      w0    <= '0;
      w1    <= '0;
    end else begin
      err_q <= cmd_fire && cmd_bad;
      case (state)
        S_IDLE: if (cmd_fire && !cmd_bad) begin
          ridx  <= '0;
          full  <= 1'b0;
          phase <= 1'b0;
          left  <= groups;
          state <= cmd_repeat ? S_RCOL : S_CODE;
        end
        S_CODE: begin
          if (in_fire) begin
            w0    <= in_data[31:0];
            w1    <= {chk_m, chk_x, in_data[47:32]};
            full  <= 1'b1;
            phase <= 1'b0;
          end else if (out_fire) begin
            if (!phase) phase <= 1'b1;
            else begin
              full <= 1'b0;
              left <= left - CNT_W'(1);
              if (left == CNT_W'(1)) state <= S_IDLE;
            end
          end
        end
        S_RCOL: if (in_fire) begin
          if (ridx == RIDX_W'(REP_WORDS - 1)) begin
            ridx  <= '0;
            state <= S_REMIT;
          end else ridx <= ridx + RIDX_W'(1);
        end
        S_REMIT: if (out_fire) begin
          ridx <= ridx + RIDX_W'(1);
          if (ridx == RIDX_W'(REP_TOTAL - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (state == S_RCOL && in_valid) rep[ridx[RW_W-1:0]] <= in_data[31:0];

  assert_err_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_ready));
  assert_err_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cmd_ready && !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !in_ready && !out_valid);
  assert_first_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CODE && in_valid && in_ready) |=> out_valid && !out_last || !out_ready);
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: tb/sim_fuse34_encoder.sv
`timescale 1ns/1ps
module sim_fuse34_encoder;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_repeat = 0, in_valid = 0, out_ready = 1;
  logic [7:0] cmd_len = 0;
  logic [47:0] in_data = 0;
  logic cmd_ready, err, in_ready, out_valid, out_last;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  fuse34_encoder u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_repeat(cmd_repeat), .cmd_len(cmd_len), .err(err), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  // {weighted popcount, xor, six data bytes}; expected words are the two halves
  localparam logic [63:0] VEC [6] = '{
    64'h0000_000000000000, 64'hA800_FFFFFFFFFFFF, 64'h0101_000000000001,
    64'h30FF_FF0000000000, 64'h5B2A_3F1F0F070301, 64'h562E_BC9A78563412 };

  int tests = 0, fails = 0, n_got = 0;
  logic [31:0] got_d [64];
  logic        got_l [64];

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && n_got < 64) begin
      got_d[n_got] = out_data; got_l[n_got] = out_last; n_got++;
    end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic do_cmd(input logic rep, input logic [7:0] len, output logic e);
    @(negedge clk); cmd_valid = 1; cmd_repeat = rep; cmd_len = len;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 0; e = err;
  endtask

  task automatic send(input logic [47:0] d);
    @(negedge clk); in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic wait_words(input int n);
    for (int k = 0; k < 200 && n_got < n; k++) @(negedge clk);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 out_ready = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic e;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
    check(in_ready == 0,  "R1 in_ready",  32'(in_ready), 0);
    check(err == 0,       "R1 err",       32'(err), 0);
    check(cmd_ready == 1, "R1 cmd_ready", 32'(cmd_ready), 1);

    // table walk: two coded payloads (24 bytes, then 12 bytes) - R3 R4 R5 R6
    base = n_got;
    for (int i = 0; i < 6; i++) begin
      if (i == 0) do_cmd(0, 8'd24, e);
      if (i == 4) do_cmd(0, 8'd12, e);
      send(VEC[i][47:0]);
    end
    wait_words(base + 12);
    check(n_got - base == 12, "R6 word count", 32'(n_got - base), 12);
    for (int i = 0; i < 6; i++) begin
      check(got_d[base+2*i] == VEC[i][31:0], "R3 first word", got_d[base+2*i], VEC[i][31:0]);
      check(got_d[base+2*i+1][23:0] == VEC[i][55:32], "R4 bytes4-5 and xor",
            got_d[base+2*i+1], VEC[i][63:32]);
      check(got_d[base+2*i+1][31:24] == VEC[i][63:56], "R5 weighted popcount",
            32'(got_d[base+2*i+1][31:24]), 32'(VEC[i][63:56]));
    end
    for (int i = 0; i < 12; i++)
      check(got_l[base+i] == (i == 7 || i == 11), "R6 out_last", 32'(got_l[base+i]),
            32'(i == 7 || i == 11));
    @(negedge clk);
    check(cmd_ready == 1, "R6 back to idle", 32'(cmd_ready), 1);

    // refused commands - R2
    base = n_got;
    do_cmd(0, 8'd25, e); check(e == 1, "R2 len 25", 32'(e), 1);
    @(negedge clk);      check(err == 0, "R2 pulse width", 32'(err), 0);
    do_cmd(0, 8'd0, e);  check(e == 1, "R2 len 0", 32'(e), 1);
    do_cmd(0, 8'd30, e); check(e == 1, "R2 len 30", 32'(e), 1);
    do_cmd(1, 8'd12, e); check(e == 1, "R2 repeat len 12", 32'(e), 1);
    check(cmd_ready == 1, "R2 stays idle", 32'(cmd_ready), 1);
    repeat (3) @(negedge clk);
    check(n_got == base, "R2 no output", 32'(n_got - base), 0);

    // idle ignores input - R10
    @(negedge clk); in_valid = 1; in_data = 48'h123456789ABC;
    repeat (5) begin
      @(negedge clk);
      check(in_ready == 0 && out_valid == 0, "R10 idle quiet", 32'({in_ready, out_valid}), 0);
    end
    in_valid = 0;
    check(n_got == base, "R10 no words", 32'(n_got - base), 0);

    // repeat mode - R7
    base = n_got;
    do_cmd(1, 8'd16, e);
    check(e == 0, "R7 accepted", 32'(e), 0);
    for (int i = 0; i < 4; i++) send({16'hDEAD, 32'hA0B0C000 + 32'(i)});
    wait_words(base + 8);
    check(n_got - base == 8, "R7 word count", 32'(n_got - base), 8);
    for (int i = 0; i < 8; i++) begin
      check(got_d[base+i] == 32'hA0B0C000 + 32'(i % 4), "R7 repeat data", got_d[base+i],
            32'hA0B0C000 + 32'(i % 4));
      check(got_l[base+i] == (i == 7), "R7 last", 32'(got_l[base+i]), 32'(i == 7));
    end

    // latency and backpressure - R9 R8
    base = n_got;
    do_cmd(0, 8'd6, e);
    set_ready(0);
    send(VEC[5][47:0]);
    check(out_valid == 1, "R9 first word next cycle", 32'(out_valid), 1);
    check(out_data == VEC[5][31:0], "R9 first word data", out_data, VEC[5][31:0]);
    repeat (3) @(negedge clk);
    check(out_valid == 1 && out_data == VEC[5][31:0], "R8 held under stall", out_data,
          VEC[5][31:0]);
    set_ready(1);
    wait_words(base + 2);
    check(n_got - base == 2, "R8 count after stall", 32'(n_got - base), 2);
    check(got_d[base+1] == VEC[5][63:32], "R8 second word", got_d[base+1], VEC[5][63:32]);
    check(got_l[base+1] == 1, "R6 last on single group", 32'(got_l[base+1]), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule